// File: doc/BRIEF.md
# Memory Bus Cycle Controller

This block sits between a simple request port and a memory that answers at its own speed. Each single read or write request becomes one bus cycle. In the first clock the controller puts the address on the address bus and asserts the read strobe or the write strobe. It then waits until the memory raises its ready line. In the last clock it drops the strobe and signals completion. With no wait states a cycle takes three clocks. A slow memory keeps ready low to add one clock per low sample.

During a write, the data bus is enabled from the second clock of the cycle for as long as the write strobe stays up. During a read, the data bus is captured on the clock edge where ready is first sampled high, and the captured word is returned together with the one-clock done pulse. The requester keeps its request on the inputs until it sees `reqReady` high at a clock edge. That edge accepts the request. `reqReady` is high when the controller is idle and also in the final clock of a cycle, so a stream of requests runs with no idle clock between cycles.

Top module: `memBusMaster`

## Requirements
- R1: During and after reset both strobes, the done output and the data-out enable are low, and `reqReady` is high.
- R2: A request accepted at a clock edge raises its strobe in the very next clock. With ready high at the first sample, done arrives in the third clock counted from the first strobe clock.
- R3: The address bus carries the accepted address from the first strobe clock through the done clock, and it does not change in between.
- R4: A read captures `busDin` at the clock edge where `busReady` is sampled high, and presents that word on `rspRdata` in the done clock.
- R5: A write asserts the write strobe from the first clock. It enables `busDout` with the accepted write data from the second clock through the last strobe clock. The enable is low in the done clock.
- R6: `busReady` is sampled at the end of each clock after the first strobe clock. Every low sample adds one clock with the strobe still asserted.
- R7: `rspDone` is high for exactly one clock per cycle, and both strobes are low in that clock.
- R8: The read strobe and the write strobe are never high in the same clock.
- R9: `reqReady` is high only when the controller is idle or in the done clock. A request presented in the done clock is accepted at that clock's end, with no idle clock in between.
- R10: Request inputs presented while `reqReady` is low are ignored. The cycle in progress keeps its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | A presented request is accepted at this clock edge |
| rspDone | output | 1 | One-clock completion pulse |
| rspRdata | output | DATA_W | Read data, valid with rspDone of a read |
| busAddr | output | ADDR_W | Address bus |
| busDout | output | DATA_W | Write data bus |
| busDoutEn | output | 1 | Write data bus drive enable |
| busRdStrobe | output | 1 | Memory read strobe, active high |
| busWrStrobe | output | 1 | Memory write strobe, active high |
| busDin | input | DATA_W | Read data bus from memory |
| busReady | input | 1 | Memory ready, sampled in the wait phase |

## Verification
The hardest case to reach is a new request arriving in the same clock that the previous cycle completes, while the new request is already waiting on the inputs during the older cycle's wait clocks. The bench produces this by issuing requests back to back with no gap. It counts the acceptances that land on a done clock, and it confirms that each completion reports the address of its own request and not the one waiting behind it. The memory model picks the number of wait states from the low address bits, and one address forces a long stretch, so the wait phase is exercised at several lengths.

// File: rtl/memBusPkg.sv
package memBusPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_WAIT = 2'd2,
    PH_LAST = 2'd3
  } phaseT;

  typedef struct packed {
    logic load;       // latch a new request
    logic capture;    // ready sampled high in wait phase
    logic strobeOn;   // strobe window (address and wait clocks)
    logic dataPhase;  // wait clocks: write data window
    logic lastPhase;  // final clock of the cycle
    logic busy;       // a cycle owns the bus
  } ctrlT;

endpackage

// File: rtl/memBusCtrl.sv
module memBusCtrl
  import memBusPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic busReady,
  output logic reqReady,
  output ctrlT ctrl
);

  phaseT phaseQ;
  phaseT phaseD;

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_IDLE: if (reqValid) phaseD = PH_ADDR;
      PH_ADDR: phaseD = PH_WAIT;
      PH_WAIT: if (busReady) phaseD = PH_LAST;
      PH_LAST: phaseD = reqValid ? PH_ADDR : PH_IDLE;
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end

  assign reqReady = (phaseQ == PH_IDLE) || (phaseQ == PH_LAST);

  always_comb begin
    ctrl.load      = reqValid && reqReady;
    ctrl.capture   = (phaseQ == PH_WAIT) && busReady;
    ctrl.strobeOn  = (phaseQ == PH_ADDR) || (phaseQ == PH_WAIT);
    ctrl.dataPhase = (phaseQ == PH_WAIT);
    ctrl.lastPhase = (phaseQ == PH_LAST);
    ctrl.busy      = (phaseQ != PH_IDLE);
  end

endmodule

// File: rtl/memBusDatapath.sv
module memBusDatapath
  import memBusPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoutEn,
  output logic              busRdStrobe,
  output logic              busWrStrobe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              writeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (ctrl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         rdataQ <= '0;
    else if (ctrl.capture && !writeQ)  rdataQ <= busDin;
  end

  assign busAddr     = ctrl.busy ? addrQ : '0;
  assign busRdStrobe = ctrl.strobeOn && !writeQ;
  assign busWrStrobe = ctrl.strobeOn && writeQ;
  assign busDoutEn   = ctrl.dataPhase && writeQ;
  assign busDout     = busDoutEn ? wdataQ : '0;
  assign rspDone     = ctrl.lastPhase;
  assign rspRdata    = rdataQ;

endmodule

// File: rtl/memBusMaster.sv
module memBusMaster
  import memBusPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoutEn,
  output logic              busRdStrobe,
  output logic              busWrStrobe,
  input  logic [DATA_W-1:0] busDin,
  input  logic              busReady
);

  ctrlT ctrl;

  memBusCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .busReady (busReady),
    .reqReady (reqReady),
    .ctrl     (ctrl)
  );

  memBusDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .busDin      (busDin),
    .rspDone     (rspDone),
    .rspRdata    (rspRdata),
    .busAddr     (busAddr),
    .busDout     (busDout),
    .busDoutEn   (busDoutEn),
    .busRdStrobe (busRdStrobe),
    .busWrStrobe (busWrStrobe)
  );

endmodule

// File: rtl/memBusChecker.sv
module memBusChecker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspDone,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busDoutEn,
  input logic              busRdStrobe,
  input logic              busWrStrobe,
  input logic              busReady
);

  logic strobe;
  assign strobe = busRdStrobe || busWrStrobe;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!busRdStrobe && !busWrStrobe && !rspDone && !busDoutEn)); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdStrobe && busWrStrobe)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R7

  AST_DONE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (!strobe && $past(strobe))); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> $stable(busAddr)); // R3

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && $past(strobe) && !busReady) |=> strobe); // R6

  AST_DOUT_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busDoutEn |-> busWrStrobe); // R5

  AST_DOUT_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (busWrStrobe && $past(busWrStrobe)) |-> busDoutEn); // R5

  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !strobe); // R9

endmodule

bind memBusMaster memBusChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .rspDone     (rspDone),
  .busAddr     (busAddr),
  .busDoutEn   (busDoutEn),
  .busRdStrobe (busRdStrobe),
  .busWrStrobe (busWrStrobe),
  .busReady    (busReady)
);

// File: tb/memBusMaster_tb_top.sv
`timescale 1ns/1ps
module memBusMaster_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  typedef struct {
    bit                isWrite;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    int                waits;
  } itemT;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqReady;
  logic              rspDone;
  logic [DATA_W-1:0] rspRdata;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busDout;
  logic              busDoutEn;
  logic              busRdStrobe;
  logic              busWrStrobe;
  logic [DATA_W-1:0] busDin;
  logic              busReady;

  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  int   startCyc = 0;
  int   b2bCnt = 0;
  bit   prevStrobe = 1'b0;
  bit   wdFired = 1'b0;
  itemT expQ[$];

  logic [DATA_W-1:0] mem    [16];
  logic [DATA_W-1:0] refMem [16];
  int                strbCnt = 0;

  always #2 clk = ~clk;

  memBusMaster #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .reqReady    (reqReady),
    .rspDone     (rspDone),
    .rspRdata    (rspRdata),
    .busAddr     (busAddr),
    .busDout     (busDout),
    .busDoutEn   (busDoutEn),
    .busRdStrobe (busRdStrobe),
    .busWrStrobe (busWrStrobe),
    .busDin      (busDin),
    .busReady    (busReady)
  );

  function automatic int waitsFor(logic [ADDR_W-1:0] a);
    return (a[3:0] == 4'hF) ? 9 : int'(a[1:0]);
  endfunction

  // memory model: wait count chosen from the address
  assign busReady = (busRdStrobe || busWrStrobe) && (strbCnt > waitsFor(busAddr));
  assign busDin   = busRdStrobe ? mem[busAddr[3:0]] : '0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]    = 32'hA500_0000 + i;
      refMem[i] = 32'hA500_0000 + i;
    end
  end

  always @(posedge clk) begin
    if (busRdStrobe || busWrStrobe) strbCnt <= strbCnt + 1;
    else                            strbCnt <= 0;
    if (busWrStrobe && busReady && busDoutEn) mem[busAddr[3:0]] <= busDout;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      bit strobe;
      cyc++;
      strobe = busRdStrobe || busWrStrobe;
      if (strobe && !prevStrobe) startCyc = cyc;
      if (busWrStrobe && prevStrobe && expQ.size() > 0) begin
        chk(busDoutEn && (busDout == expQ[0].data), "R5 dout window",
            {31'd0, busDoutEn, busDout}, {32'd1, expQ[0].data});
      end
      if (rspDone) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          itemT it;
          it = expQ.pop_front();
          chk((cyc - startCyc + 1) == 3 + it.waits, "R2 R6 cycle length",
              cyc - startCyc + 1, 3 + it.waits);
          chk(busAddr == it.addr, "R3 R10 address held", busAddr, it.addr);
          chk(!busRdStrobe && !busWrStrobe && !busDoutEn, "R7 R8 strobes low at done",
              {busRdStrobe, busWrStrobe, busDoutEn}, 0);
          chk(reqReady, "R9 ready in done clock", reqReady, 1);
          if (!it.isWrite) chk(rspRdata == it.data, "R4 read data", rspRdata, it.data);
        end
      end
      prevStrobe = strobe;
    end
  end

  // driver: present a request and hold it until accepted
  task automatic doReq(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    itemT it;
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = a;
    reqWdata = d;
    forever begin
      if (reqReady) begin
        it.isWrite = wr;
        it.addr    = a;
        it.waits   = waitsFor(a);
        if (wr) begin
          it.data = d;
          refMem[a[3:0]] = d;
        end else begin
          it.data = refMem[a[3:0]];
        end
        if (rspDone) b2bCnt++;
        expQ.push_back(it);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0;
    reqAddr  = 16'hDEAD;
    reqWdata = 32'hBAD0_BAD0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    reqValid = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        reqValid = 1'b1;                 // must be ignored in reset
        repeat (3) @(negedge clk);
        chk(!busRdStrobe && !busWrStrobe && !rspDone && !busDoutEn, "R1 reset outputs",
            {busRdStrobe, busWrStrobe, rspDone, busDoutEn}, 0);
        rstN = 1'b1;
        reqValid = 1'b0;
        @(negedge clk);
        chk(reqReady && !rspDone, "R1 idle after reset", {reqReady, rspDone}, 2'b10);

        // reads with 0..3 wait clocks and a long stretch
        for (int a = 0; a < 4; a++) begin
          doReq(1'b0, 16'(a), '0);
          idle(1);
          drain();
        end
        doReq(1'b0, 16'h000F, '0);
        drain();

        // writes followed by reads of the same words
        doReq(1'b1, 16'h0004, 32'h1234_5678); drain();
        doReq(1'b1, 16'h0005, 32'hCAFE_F00D); drain();
        doReq(1'b0, 16'h0004, '0);            drain();
        doReq(1'b0, 16'h0005, '0);            drain();

        // back-to-back stream: next request waits on the inputs
        b2bCnt = 0;
        doReq(1'b1, 16'h0006, 32'h0BAD_CAFE);
        doReq(1'b1, 16'h0007, 32'h7777_0007);
        doReq(1'b0, 16'h0006, '0);
        doReq(1'b0, 16'h0007, '0);
        drain();
        chk(b2bCnt == 3, "R9 back-to-back acceptances", b2bCnt, 3);

        doReq(1'b0, 16'h000C, '0);
        idle(1);
        drain();
        chk(expQ.size() == 0, "R10 no extra cycles", expQ.size(), 0);
        chk(!busRdStrobe && !busWrStrobe && reqReady, "R1 idle at end",
            {busRdStrobe, busWrStrobe, reqReady}, 1);
      end
      begin
        repeat (20000) @(posedge clk);
        wdFired = 1'b1;
      end
    join_any
    disable fork;
    if (wdFired) chk(1'b0, "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule